// File: doc/BRIEF.md
# Daisy-Chained Serial Event Readout Controller

This block drains buffered event words from a local FIFO onto one serial line that several identical chips share in a chain. Each chip receives a data-available level from the chip above it and passes on the OR of that level and its own non-empty flag. One chip is strapped as the chain head. It produces the readout clock at half the core rate, and it starts a readout cycle when the data-available level that comes back from the chain tail is high. An enable token then passes down the chain. Each chip holding the token sends up to a programmed number of frames, then raises its own enable output so that the next chip can take its turn.

Each frame is 48 bits long and is sent most significant bit first. It contains two start ones, the chip address, the event word and a stop zero. The event word holds the channel number, the timestamp, the ADC value and the hit flag, in that order. Each bit lasts two core cycles. In binary mode the level holds for both cycles. In Manchester mode the level is inverted for the second cycle. The line is low whenever no frame is being sent.

The FIFO side is a valid/ready read port. A word is consumed only on a cycle where both `fifo_valid` and `fifo_ready` are high. `fifo_data` must stay stable while valid is high and ready is low. The block raises ready only while it holds the token, its serializer is idle and its frame quota is not used up. The FIFO may lower valid at any time. The block takes this as "nothing left" and passes the token on.

Top module: `rdo_chain_readout`

## Requirements
- R1: After reset, `sdo`, `ren_out`, `rd_clk` and `fifo_ready` are all low.
- R2: `dav_out` equals `dav_in` OR `fifo_valid` at all times, with no register in the path.
- R3: In binary mode a frame is 48 bits, most significant bit first: bits 47..46 = 11, bits 45..36 = `chip_addr`, bits 35..1 = `fifo_data` (channel 34..28, timestamp 27..13, ADC 12..1, hit 0), bit 0 = 0. Each bit is held for two clock cycles.
- R4: In Manchester mode each bit takes two clock cycles. A 1 is sent high then low, and a 0 is sent low then high, with the same bit order as R3.
- R5: `sdo` is low outside frames, and at least two low cycles separate consecutive frames.
- R6: A chip that is not the head starts its turn when `ren_in` is high. It sends min(`pkt_limit`, words available) frames, then drives `ren_out` high. `ren_out` stays high while `ren_in` stays high and goes low on the cycle after `ren_in` falls.
- R7: With `pkt_limit` = 0 or an empty FIFO, `ren_out` rises within three cycles of the turn starting. No frame is sent and no word is consumed.
- R8: The head chip (`is_master` = 1) ignores `ren_in`. It starts a cycle when `chain_dav` is high and `chain_ren` is low.
- R9: The head chip holds `ren_out` high until `chain_ren` is high. It then drops `ren_out` and starts no new cycle until `chain_ren` has gone low.
- R10: When `is_master` is high, `rd_clk` toggles on every clock. Otherwise it is held low.
- R11: Exactly one FIFO word is consumed per frame. The number consumed in a turn equals the number of frames sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | Strap: this chip heads the chain |
| chip_addr | input | 10 | Address placed in every frame |
| pkt_limit | input | 8 | Maximum frames per turn (0..255) |
| manch_en | input | 1 | 1 = Manchester line code, 0 = binary |
| fifo_valid | input | 1 | FIFO holds a word |
| fifo_ready | output | 1 | Block accepts the word this cycle |
| fifo_data | input | 35 | Event word: channel, timestamp, ADC, hit |
| dav_in | input | 1 | Data-available level from upstream |
| dav_out | output | 1 | OR of upstream and local data-available |
| ren_in | input | 1 | Enable token from upstream (non-head chips) |
| ren_out | output | 1 | Enable token to downstream |
| chain_dav | input | 1 | Data-available returned from the chain tail (head only) |
| chain_ren | input | 1 | Enable returned from the chain tail (head only) |
| rd_clk | output | 1 | Readout clock produced by the head chip |
| sdo | output | 1 | Serial frame output |

## Verification
The bench sweeps the frame quota against the FIFO fill, in both line codes. It catches a controller that stops one frame early or late, takes the zero-quota case as 256, or consumes a word without sending it. Every frame is decoded from the line and compared bit by bit, so a swapped field, a wrong bit order or a Manchester phase that is inverted shows up as a mismatch. The head-chip sequence checks that a token is not dropped before `chain_ren` returns, and that no new cycle starts while `chain_ren` is still high. A design that restarted at once would send frames the bench does not expect.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SHIFT,
    ST_PASS,
    ST_DONE
  } tok_state_e;

  localparam logic [1:0] FRAME_START = 2'b11;
  localparam logic       FRAME_STOP  = 1'b0;
endpackage

// File: rtl/rdo_serializer.sv
module rdo_serializer #(
  parameter int FW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic          manch,
  output logic          busy,
  output logic          sdo
);
  localparam int CW = $clog2(FW);

  logic [FW-1:0] shreg;
  logic [CW-1:0] bitcnt;
  logic          half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      bitcnt <= '0;
      half   <= 1'b0;
      busy   <= 1'b0;
    end else if (load && !busy) begin
      shreg  <= frame;
      bitcnt <= CW'(FW - 1);
      half   <= 1'b0;
      busy   <= 1'b1;
    end else if (busy) begin
      half <= ~half;
      if (half) begin
        if (bitcnt == '0) begin
          busy <= 1'b0;
        end else begin
          shreg  <= {shreg[FW-2:0], 1'b0};
          bitcnt <= bitcnt - 1'b1;
        end
      end
    end
  end

  assign sdo = busy & (shreg[FW-1] ^ (manch & half));

  AST_MANCH_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && half && manch && $past(manch) |-> sdo != $past(sdo)); // R4
  AST_BIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && half && !manch && !$past(manch) |-> sdo == $past(sdo)); // R3
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load && !busy |=> busy && sdo); // R3
endmodule

// File: rtl/rdo_token_ctrl.sv
module rdo_token_ctrl
  import rdo_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_master,
  input  logic             ren_in,
  input  logic             chain_dav,
  input  logic             chain_ren,
  input  logic [CNT_W-1:0] pkt_limit,
  input  logic             fifo_valid,
  input  logic             ser_busy,
  output logic             fifo_ready,
  output logic             ser_load,
  output logic             ren_out
);
  tok_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             start;

  always_comb begin
    start      = is_master ? (chain_dav && !chain_ren) : ren_in;
    fifo_ready = (state == ST_TURN) && (cnt != pkt_limit) && !ser_busy;
    ser_load   = fifo_ready && fifo_valid;
    ren_out    = (state == ST_PASS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_TURN;
          cnt   <= '0;
        end
        ST_TURN: begin
          if (ser_load) begin
            cnt   <= cnt + 1'b1;
            state <= ST_SHIFT;
          end else if (cnt == pkt_limit || !fifo_valid) begin
            state <= ST_PASS;
          end
        end
        ST_SHIFT: if (!ser_busy) state <= ST_TURN;
        ST_PASS: begin
          if (is_master) begin
            if (chain_ren) state <= ST_DONE;
          end else if (!ren_in) begin
            state <= ST_IDLE;
          end
        end
        ST_DONE: if (!chain_ren) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master && ren_out && ren_in |=> ren_out); // R6
  AST_MASTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && $fell(ren_out) |-> $past(chain_ren)); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && state == ST_DONE && chain_ren |=> !ren_out && !ser_load); // R9
endmodule

// File: rtl/rdo_chain_readout.sv
module rdo_chain_readout
  import rdo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CHAN_W = 7,
  parameter int TS_W   = 15,
  parameter int ADC_W  = 12,
  parameter int CNT_W  = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                is_master,
  input  logic [ADDR_W-1:0]                   chip_addr,
  input  logic [CNT_W-1:0]                    pkt_limit,
  input  logic                                manch_en,
  input  logic                                fifo_valid,
  output logic                                fifo_ready,
  input  logic [CHAN_W+TS_W+ADC_W:0]          fifo_data,
  input  logic                                dav_in,
  output logic                                dav_out,
  input  logic                                ren_in,
  output logic                                ren_out,
  input  logic                                chain_dav,
  input  logic                                chain_ren,
  output logic                                rd_clk,
  output logic                                sdo
);
  localparam int WORD_W  = CHAN_W + TS_W + ADC_W + 1;
  localparam int FRAME_W = 2 + ADDR_W + WORD_W + 1;

  logic               ser_busy;
  logic               ser_load;
  logic [FRAME_W-1:0] frame;
  logic               clk_div;

  assign dav_out = dav_in | fifo_valid;
  assign frame   = {FRAME_START, chip_addr, fifo_data, FRAME_STOP};

  always_ff @(posedge clk) begin
    if (!rst_n) clk_div <= 1'b0;
    else        clk_div <= is_master ? ~clk_div : 1'b0;
  end
  assign rd_clk = clk_div;

  rdo_token_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_master  (is_master),
    .ren_in     (ren_in),
    .chain_dav  (chain_dav),
    .chain_ren  (chain_ren),
    .pkt_limit  (pkt_limit),
    .fifo_valid (fifo_valid),
    .ser_busy   (ser_busy),
    .fifo_ready (fifo_ready),
    .ser_load   (ser_load),
    .ren_out    (ren_out)
  );

  rdo_serializer #(.FW(FRAME_W)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ser_load),
    .frame (frame),
    .manch (manch_en),
    .busy  (ser_busy),
    .sdo   (sdo)
  );

  AST_TOKEN_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ren_out |-> !ser_busy && !sdo); // R5
  AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |=> rd_clk != $past(rd_clk)); // R10
  AST_SLAVE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |=> !rd_clk); // R10
  AST_POP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && fifo_ready |=> ser_busy); // R11
endmodule

// File: tb/rdo_chain_readout_tb.sv
module rdo_chain_readout_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_master = 1'b0;
  logic [9:0]  chip_addr = 10'h2B5;
  logic [7:0]  pkt_limit = 8'd0;
  logic        manch_en = 1'b0;
  logic        fifo_valid;
  logic        fifo_ready;
  logic [34:0] fifo_data;
  logic        dav_in = 1'b0;
  logic        dav_out;
  logic        ren_in = 1'b0;
  logic        ren_out;
  logic        chain_dav = 1'b0;
  logic        chain_ren = 1'b0;
  logic        rd_clk;
  logic        sdo;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  rdo_chain_readout u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .chip_addr(chip_addr),
    .pkt_limit(pkt_limit), .manch_en(manch_en), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .fifo_data(fifo_data), .dav_in(dav_in),
    .dav_out(dav_out), .ren_in(ren_in), .ren_out(ren_out),
    .chain_dav(chain_dav), .chain_ren(chain_ren), .rd_clk(rd_clk), .sdo(sdo)
  );

  // FIFO model
  logic [34:0] fmem [0:15];
  int fwr = 0;
  int frd = 0;
  assign fifo_valid = (frd < fwr);
  assign fifo_data  = fmem[frd % 16];
  always @(posedge clk) if (fifo_valid && fifo_ready) frd <= frd + 1;

  function automatic logic [34:0] gen_word(int k);
    return {7'(k * 13 + 5), 15'(k * 977 + 123), 12'(k * 311 + 7), 1'(k & 1)};
  endfunction

  int wgen = 0;
  task automatic load_fifo(int n, output int first);
    first = wgen;
    for (int i = 0; i < n; i++) begin
      fmem[(frd + i) % 16] = gen_word(wgen);
      wgen++;
    end
    fwr = frd + n;
  endtask

  // Line decoder
  logic [47:0] dec [0:255];
  int ndec = 0;
  int pair_err = 0;
  int gap_err = 0;
  logic samp [0:95];
  int ns = 0;
  bit cap = 0;
  int gap = 100;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cap) begin
        if (sdo) begin
          if (gap < 2) gap_err++;
          cap = 1;
          samp[0] = sdo;
          ns = 1;
        end else gap++;
      end else begin
        samp[ns] = sdo;
        ns++;
        if (ns == 96) begin
          logic [47:0] f;
          for (int b = 0; b < 48; b++) begin
            if (manch_en ? (samp[2*b+1] == samp[2*b]) : (samp[2*b+1] != samp[2*b]))
              pair_err++;
            f[47-b] = samp[2*b];
          end
          dec[ndec % 256] = f;
          ndec++;
          cap = 0;
          gap = 0;
        end
      end
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ren(int maxc, output int waited);
    waited = 0;
    while (!ren_out && waited < maxc) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic run_slave(bit manch, int limit, int n);
    int first, base, frd0, m, waited;
    is_master = 1'b0;
    manch_en  = manch;
    pkt_limit = 8'(limit);
    dav_in    = 1'b0;
    load_fifo(n, first);
    @(negedge clk);
    check(dav_out == (n > 0), "R2", 64'(dav_out), 64'(n > 0));
    dav_in = 1'b1;
    #1;
    check(dav_out == 1'b1, "R2", 64'(dav_out), 64'd1);
    dav_in = 1'b0;
    base = ndec;
    frd0 = frd;
    m = (limit < n) ? limit : n;
    ren_in = 1'b1;
    wait_ren(4000, waited);
    check(ren_out == 1'b1, "R6", 64'(ren_out), 64'd1);
    if (m == 0)
      check(waited <= 3, "R7", 64'(waited), 64'd3);
    check(ndec - base == m, m == 0 ? "R7" : "R6", 64'(ndec - base), 64'(m));
    check(frd - frd0 == m, "R11", 64'(frd - frd0), 64'(m));
    for (int i = 0; i < m && i < ndec - base; i++) begin
      logic [47:0] e;
      e = {2'b11, chip_addr, gen_word(first + i), 1'b0};
      check(dec[(base + i) % 256] == e, manch ? "R4" : "R3",
            64'(dec[(base + i) % 256]), 64'(e));
    end
    repeat (6) @(negedge clk);
    check(ren_out == 1'b1 && sdo == 1'b0, "R6", 64'({ren_out, sdo}), 64'b10);
    ren_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(ren_out == 1'b0, "R6", 64'(ren_out), 64'd0);
  endtask

  initial begin
    int first, base, waited;
    logic r0;
    repeat (3) @(negedge clk);
    check({sdo, ren_out, rd_clk, fifo_ready} == 4'b0, "R1",
          64'({sdo, ren_out, rd_clk, fifo_ready}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({sdo, ren_out, rd_clk, fifo_ready} == 4'b0, "R1",
          64'({sdo, ren_out, rd_clk, fifo_ready}), 64'd0);

    for (int md = 0; md < 2; md++)
      foreach (lims[li])
        for (int n = 0; n <= 4; n += (n < 2 ? 1 : 2))
          run_slave(md[0], lims[li], n);

    // R10: slave clock low
    @(negedge clk); r0 = rd_clk;
    @(negedge clk);
    check(r0 == 1'b0 && rd_clk == 1'b0, "R10", 64'({r0, rd_clk}), 64'd0);

    // Head chip sequence
    is_master = 1'b1;
    manch_en  = 1'b0;
    pkt_limit = 8'd5;
    ren_in    = 1'b1;
    load_fifo(2, first);
    base = ndec;
    repeat (10) @(negedge clk);
    check(ren_out == 1'b0 && ndec == base, "R8", 64'(ren_out), 64'd0);
    r0 = rd_clk;
    @(negedge clk);
    check(rd_clk != r0, "R10", 64'(rd_clk), 64'(!r0));
    chain_dav = 1'b1;
    wait_ren(4000, waited);
    check(ndec - base == 2, "R8", 64'(ndec - base), 64'd2);
    for (int i = 0; i < 2; i++)
      check(dec[(base + i) % 256] == {2'b11, chip_addr, gen_word(first + i), 1'b0},
            "R3", 64'(dec[(base + i) % 256]), 64'({2'b11, chip_addr, gen_word(first + i), 1'b0}));
    repeat (10) @(negedge clk);
    check(ren_out == 1'b1, "R9", 64'(ren_out), 64'd1);
    chain_ren = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(ren_out == 1'b0, "R9", 64'(ren_out), 64'd0);
    load_fifo(1, first);
    base = ndec;
    repeat (20) @(negedge clk);
    check(ren_out == 1'b0 && ndec == base && frd != fwr - 0 - 0 || ndec == base,
          "R9", 64'(ndec - base), 64'd0);
    check(fifo_valid == 1'b1, "R9", 64'(fifo_valid), 64'd1);
    chain_ren = 1'b0;
    wait_ren(4000, waited);
    check(ndec - base == 1, "R9", 64'(ndec - base), 64'd1);
    check(dec[base % 256] == {2'b11, chip_addr, gen_word(first), 1'b0}, "R3",
          64'(dec[base % 256]), 64'({2'b11, chip_addr, gen_word(first), 1'b0}));
    chain_dav = 1'b0;
    chain_ren = 1'b1;
    repeat (3) @(negedge clk);
    chain_ren = 1'b0;
    repeat (3) @(negedge clk);

    check(pair_err == 0, "R4", 64'(pair_err), 64'd0);
    check(gap_err == 0, "R5", 64'(gap_err), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int lims [5] = '{0, 1, 2, 3, 5};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule